// File: doc/BRIEF.md
# Transport Stream Sync Lock Detector

This block sits behind a byte-wide transport-stream input and finds where the packets begin. Bytes arrive with a valid strobe. The block looks for a programmable sync token and checks that the token comes back at the programmed packet spacing. It declares lock after a programmed number of good syncs in a row. Once locked, it passes the stream on with a start-of-packet flag on each sync position. Only after a programmed number of missed syncs in a row does it give up lock and return to searching. The separate lock and drop counts give hysteresis, so one corrupted sync byte does not break an established lock.

The token, packet length, lock count and drop count are configuration inputs. They are held steady while traffic runs, and an integration normally ties them to 0x47, 188, 9 and 9. A lock status output shows the current state. A sticky lost-lock flag records that lock was dropped, and it stays set until a clear pulse arrives. The block has three internal states: hunting, verifying and locked. Outputs are registered, so every accepted byte shows up on the output one clock after it is taken.

Top module: `ts_sync_lock`

## Requirements
- R1: After reset, out_vld, out_sop, locked and lock_lost are all 0.
- R2: While hunting, the first accepted byte equal to cfg_token starts verification with a good-sync count of 1. No byte is output while hunting or verifying.
- R3: When cfg_lock_cnt consecutive tokens are seen exactly cfg_pkt_len accepted bytes apart, the block locks. The sync byte that completes the count is output one cycle after it is accepted, with out_sop=1, and locked=1 in that same cycle. A cfg_lock_cnt of 0 or 1 locks on the first token.
- R4: A non-token byte at an expected sync position during verification sends the block back to hunting. The good count is discarded, and the search resumes with the very next accepted byte.
- R5: While locked, every accepted byte appears on out_byte with out_vld=1 one cycle after it is accepted. out_sop=1 marks exactly the expected sync positions, including positions where the token was missing.
- R6: While locked, a token at a sync position clears the consecutive-miss count, so misses that are not consecutive never drop lock.
- R7: The cfg_drop_cnt-th consecutive miss drops lock: locked goes to 0, the byte at that position is not output, and hunting restarts with the next byte. A cfg_drop_cnt of 0 or 1 drops on the first miss.
- R8: lock_lost goes to 1 in the cycle lock is dropped. It stays at 1 until a clock edge where lost_clr=1 clears it, and a drop in the same cycle as a clear wins.
- R9: A cycle with byte_vld=0 is ignored whatever byte_in holds. No output is produced, no state changes, and packet spacing counts accepted bytes only.
- R10: The token compare uses cfg_token, so a stream synced on any other token value (for example 0xB8) locks, and 0x47 bytes are then treated as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_in | input | DATA_W | Incoming stream byte |
| byte_vld | input | 1 | byte_in holds a byte this cycle |
| cfg_token | input | DATA_W | Sync token value |
| cfg_pkt_len | input | LEN_W | Packet length in bytes (at least 1) |
| cfg_lock_cnt | input | CNT_W | Consecutive good syncs needed to lock |
| cfg_drop_cnt | input | CNT_W | Consecutive missed syncs that drop lock |
| lost_clr | input | 1 | Write-1 clear of lock_lost |
| out_byte | output | DATA_W | Aligned output byte |
| out_vld | output | 1 | out_byte is valid |
| out_sop | output | 1 | out_byte is at a packet sync position |
| locked | output | 1 | Block is locked to packet alignment |
| lock_lost | output | 1 | Sticky: lock has been dropped since last clear |

## Verification
The bench builds the block with its default parameters (8-bit bytes, 8-bit length, 4-bit counts). It then programs the configuration inputs per scenario. Most scenarios use 8-byte packets, a lock count of 3 and a drop count of 2, so that each lock, verification failure and drop boundary falls within a few dozen bytes. One scenario runs the usual 188-byte, 9-good, 9-bad setting to reach both full thresholds. Another scenario uses a lock count of 1 and a different token value.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;

endpackage

// File: rtl/ts_pos_counter.sv
// Tracks the byte position inside the current packet; position 0 is the
// expected sync byte.
module ts_pos_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             run,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             at_sync
);

  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] pos_q;
  logic [LEN_W-1:0] pos_d;
  logic [LEN_W-1:0] last_pos;
  logic [LEN_W-1:0] pos_inc;

  assign last_pos = cfg_len - ONE;
  assign pos_inc  = (pos_q >= last_pos) ? '0 : pos_q + ONE;
  assign at_sync  = (pos_q == '0);

  always_comb begin
    pos_d = pos_q;
    if (load) begin
      pos_d = (last_pos == '0) ? '0 : ONE;
    end else if (run) begin
      pos_d = pos_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (en) begin
      pos_q <= pos_d;
    end
  end

endmodule

// File: rtl/ts_sync_fsm.sv
// Hunt / verify / locked control with good-sync and miss counters.
module ts_sync_fsm
  import ts_sync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DATA_W-1:0] cfg_token,
  input  logic [CNT_W-1:0]  cfg_lock_cnt,
  input  logic [CNT_W-1:0]  cfg_drop_cnt,
  input  logic              at_sync,
  output logic              pos_load,
  output logic              pos_run,
  output logic              emit,
  output logic              emit_sop,
  output logic              drop_evt,
  output logic              locked
);

  localparam logic [CNT_W:0]   INC1 = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT1 = {{(CNT_W-1){1'b0}}, 1'b1};

  sync_state_e      state_q, state_d;
  logic [CNT_W-1:0] good_q, good_d;
  logic [CNT_W-1:0] miss_q, miss_d;
  logic [CNT_W:0]   good_inc;
  logic [CNT_W:0]   miss_inc;
  logic             is_tok;

  assign is_tok   = (byte_in == cfg_token);
  assign good_inc = {1'b0, good_q} + INC1;
  assign miss_inc = {1'b0, miss_q} + INC1;
  assign locked   = (state_q == ST_LOCKED);

  always_comb begin
    state_d  = state_q;
    good_d   = good_q;
    miss_d   = miss_q;
    pos_load = 1'b0;
    pos_run  = 1'b0;
    emit     = 1'b0;
    emit_sop = 1'b0;
    drop_evt = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (is_tok) begin
          pos_load = 1'b1;
          good_d   = CNT1;
          miss_d   = '0;
          if (cfg_lock_cnt <= CNT1) begin
            state_d  = ST_LOCKED;
            emit     = 1'b1;
            emit_sop = 1'b1;
          end else begin
            state_d = ST_VERIFY;
          end
        end
      end
      ST_VERIFY: begin
        pos_run = 1'b1;
        if (at_sync) begin
          if (is_tok) begin
            good_d = good_inc[CNT_W-1:0];
            if (good_inc >= {1'b0, cfg_lock_cnt}) begin
              state_d  = ST_LOCKED;
              miss_d   = '0;
              emit     = 1'b1;
              emit_sop = 1'b1;
            end
          end else begin
            state_d = ST_HUNT;
            good_d  = '0;
          end
        end
      end
      ST_LOCKED: begin
        pos_run  = 1'b1;
        emit     = 1'b1;
        emit_sop = at_sync;
        if (at_sync) begin
          if (is_tok) begin
            miss_d = '0;
          end else if (miss_inc >= {1'b0, cfg_drop_cnt}) begin
            state_d  = ST_HUNT;
            emit     = 1'b0;
            emit_sop = 1'b0;
            drop_evt = 1'b1;
            miss_d   = '0;
            good_d   = '0;
          end else begin
            miss_d = miss_inc[CNT_W-1:0];
          end
        end
      end
      default: begin
        state_d = ST_HUNT;
        good_d  = '0;
        miss_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      good_q  <= '0;
      miss_q  <= '0;
    end else if (byte_vld) begin
      state_q <= state_d;
      good_q  <= good_d;
      miss_q  <= miss_d;
    end
  end

endmodule

// File: rtl/ts_out_stage.sv
// Registered output of aligned bytes plus the sticky lost-lock flag.
module ts_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              emit,
  input  logic              emit_sop,
  input  logic              drop_evt,
  input  logic              lost_clr,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_vld,
  output logic              out_sop,
  output logic              lock_lost
);

  logic              vld_d, sop_d, lost_d, byte_en;
  logic [DATA_W-1:0] byte_q;
  logic              vld_q, sop_q, lost_q;

  assign byte_en = byte_vld & emit;

  always_comb begin
    vld_d  = byte_en;
    sop_d  = byte_en & emit_sop;
    lost_d = lost_q;
    if (lost_clr) begin
      lost_d = 1'b0;
    end
    if (byte_vld & drop_evt) begin
      lost_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      sop_q  <= sop_d;
      lost_q <= lost_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_en) begin
      byte_q <= byte_in;
    end
  end

  assign out_byte  = byte_q;
  assign out_vld   = vld_q;
  assign out_sop   = sop_q;
  assign lock_lost = lost_q;

endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] cfg_token,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic [CNT_W-1:0]  cfg_lock_cnt,
  input  logic [CNT_W-1:0]  cfg_drop_cnt,
  input  logic              lost_clr,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_vld,
  output logic              out_sop,
  output logic              locked,
  output logic              lock_lost
);

  logic at_sync, pos_load, pos_run, emit, emit_sop, drop_evt;

  ts_pos_counter #(.LEN_W(LEN_W)) pos_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (byte_vld),
    .load    (pos_load),
    .run     (pos_run),
    .cfg_len (cfg_pkt_len),
    .at_sync (at_sync)
  );

  ts_sync_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_in      (byte_in),
    .cfg_token    (cfg_token),
    .cfg_lock_cnt (cfg_lock_cnt),
    .cfg_drop_cnt (cfg_drop_cnt),
    .at_sync      (at_sync),
    .pos_load     (pos_load),
    .pos_run      (pos_run),
    .emit         (emit),
    .emit_sop     (emit_sop),
    .drop_evt     (drop_evt),
    .locked       (locked)
  );

  ts_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .emit      (emit),
    .emit_sop  (emit_sop),
    .drop_evt  (drop_evt),
    .lost_clr  (lost_clr),
    .out_byte  (out_byte),
    .out_vld   (out_vld),
    .out_sop   (out_sop),
    .lock_lost (lock_lost)
  );

endmodule

// File: rtl/ts_sync_lock_chk.sv
module ts_sync_lock_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              lost_clr,
  input logic [DATA_W-1:0] out_byte,
  input logic              out_vld,
  input logic              out_sop,
  input logic              locked,
  input logic              lock_lost
);

  // R5
  sop_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_vld);

  // R2
  out_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> locked);

  // R3
  lock_rise_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (out_sop && out_vld));

  // R8
  drop_sets_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> lock_lost);

  // R8
  lost_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_lost) |-> $past(lost_clr));

  // R9
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !out_vld);

  // R9
  idle_hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(locked));

endmodule

bind ts_sync_lock ts_sync_lock_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_vld  (byte_vld),
  .lost_clr  (lost_clr),
  .out_byte  (out_byte),
  .out_vld   (out_vld),
  .out_sop   (out_sop),
  .locked    (locked),
  .lock_lost (lock_lost)
);

// File: tb/ts_sync_lock_tb_top.sv
module ts_sync_lock_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] byte_in;
  logic       byte_vld;
  logic [7:0] cfg_token;
  logic [7:0] cfg_pkt_len;
  logic [3:0] cfg_lock_cnt;
  logic [3:0] cfg_drop_cnt;
  logic       lost_clr;
  logic [7:0] out_byte;
  logic       out_vld;
  logic       out_sop;
  logic       locked;
  logic       lock_lost;

  int checks = 0;
  int errors = 0;

  ts_sync_lock dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_in      (byte_in),
    .byte_vld     (byte_vld),
    .cfg_token    (cfg_token),
    .cfg_pkt_len  (cfg_pkt_len),
    .cfg_lock_cnt (cfg_lock_cnt),
    .cfg_drop_cnt (cfg_drop_cnt),
    .lost_clr     (lost_clr),
    .out_byte     (out_byte),
    .out_vld      (out_vld),
    .out_sop      (out_sop),
    .locked       (locked),
    .lock_lost    (lock_lost)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] tok, input logic [7:0] len,
                          input logic [3:0] lk, input logic [3:0] dr);
    rst_n        = 1'b0;
    byte_vld     = 1'b0;
    byte_in      = 8'h00;
    lost_clr     = 1'b0;
    cfg_token    = tok;
    cfg_pkt_len  = len;
    cfg_lock_cnt = lk;
    cfg_drop_cnt = dr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive at negedge, check the registered result after the edge.
  task automatic step(input logic [7:0] b, input bit vld, input bit ev,
                      input bit es, input bit el, input string tag);
    @(negedge clk);
    byte_in  = b;
    byte_vld = vld;
    @(posedge clk);
    #1;
    check((out_vld == ev) && (out_sop == (ev & es)) && (locked == el) &&
          (!ev || out_byte == b), tag,
          {20'd0, out_vld, out_sop, locked, 1'b0, out_byte},
          {20'd0, ev, ev & es, el, 1'b0, b});
  endtask

  function automatic logic [7:0] dbyte(input int i);
    return 8'((i % 32) + 1);
  endfunction

  task automatic send_pkt(input logic [7:0] sb, input bit ev, input bit el,
                          input string tag);
    step(sb, 1'b1, ev, 1'b1, el, tag);
    for (int i = 1; i < int'(cfg_pkt_len); i++) begin
      step(dbyte(i), 1'b1, ev, 1'b0, el, tag);
    end
  endtask

  task automatic t_reset();
    do_reset(8'h47, 8'd8, 4'd3, 4'd2);
    #1;
    check(!out_vld && !out_sop && !locked && !lock_lost, "R1 reset state",
          {28'd0, out_vld, out_sop, locked, lock_lost}, 32'd0);
  endtask

  task automatic t_lock();
    do_reset(8'h47, 8'd8, 4'd3, 4'd2);
    // R9: idle cycles carrying the token must not start a search
    step(8'h47, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle in hunt");
    step(8'h47, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle in hunt");
    step(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, "R2 junk no output");
    step(8'h02, 1'b1, 1'b0, 1'b0, 1'b0, "R2 junk no output");
    send_pkt(8'h47, 1'b0, 1'b0, "R2 verify no output");
    send_pkt(8'h47, 1'b0, 1'b0, "R2 verify no output");
    send_pkt(8'h47, 1'b1, 1'b1, "R3 lock on third sync");
    send_pkt(8'h47, 1'b1, 1'b1, "R5 locked pass-through");
  endtask

  task automatic t_verify_miss();
    do_reset(8'h47, 8'd8, 4'd3, 4'd2);
    send_pkt(8'h47, 1'b0, 1'b0, "R2 verify count 1");
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R4 miss in verify");
    send_pkt(8'h47, 1'b0, 1'b0, "R4 restart count 1");
    send_pkt(8'h47, 1'b0, 1'b0, "R4 restart count 2");
    send_pkt(8'h47, 1'b1, 1'b1, "R4 lock after full recount");
  endtask

  task automatic t_drop();
    do_reset(8'h47, 8'd8, 4'd3, 4'd2);
    send_pkt(8'h47, 1'b0, 1'b0, "R3 pre-lock");
    send_pkt(8'h47, 1'b0, 1'b0, "R3 pre-lock");
    send_pkt(8'h47, 1'b1, 1'b1, "R3 lock");
    send_pkt(8'h00, 1'b1, 1'b1, "R5 sop on missed sync");
    send_pkt(8'h47, 1'b1, 1'b1, "R6 good resets misses");
    send_pkt(8'h00, 1'b1, 1'b1, "R6 single miss held");
    send_pkt(8'h47, 1'b1, 1'b1, "R6 good resets misses");
    send_pkt(8'h00, 1'b1, 1'b1, "R7 first of two misses");
    #1;
    check(!lock_lost, "R8 no flag before drop", {31'd0, lock_lost}, 32'd0);
    send_pkt(8'h00, 1'b0, 1'b0, "R7 drop on second miss");
    check(lock_lost, "R8 flag set on drop", {31'd0, lock_lost}, 32'd1);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle after drop");
    check(lock_lost, "R8 flag sticky", {31'd0, lock_lost}, 32'd1);
    @(negedge clk);
    lost_clr = 1'b1;
    @(negedge clk);
    lost_clr = 1'b0;
    check(!lock_lost, "R8 flag cleared", {31'd0, lock_lost}, 32'd0);
  endtask

  task automatic t_gaps();
    do_reset(8'h47, 8'd8, 4'd3, 4'd2);
    send_pkt(8'h47, 1'b0, 1'b0, "R9 pre-lock");
    send_pkt(8'h47, 1'b0, 1'b0, "R9 pre-lock");
    send_pkt(8'h47, 1'b1, 1'b1, "R9 lock");
    step(8'h47, 1'b1, 1'b1, 1'b1, 1'b1, "R9 sync before gaps");
    for (int i = 1; i < 8; i++) begin
      step(8'h47, 1'b0, 1'b0, 1'b0, 1'b1, "R9 idle cycle ignored");
      step(dbyte(i), 1'b1, 1'b1, 1'b0, 1'b1, "R9 data after gap");
    end
    send_pkt(8'h47, 1'b1, 1'b1, "R9 alignment kept across gaps");
  endtask

  task automatic t_token();
    do_reset(8'hB8, 8'd8, 4'd1, 4'd1);
    send_pkt(8'h47, 1'b0, 1'b0, "R10 old token ignored");
    send_pkt(8'hB8, 1'b1, 1'b1, "R3 lock count 1 immediate");
    send_pkt(8'hB8, 1'b1, 1'b1, "R10 locked on other token");
    send_pkt(8'h47, 1'b0, 1'b0, "R7 drop count 1");
    check(lock_lost, "R8 flag after single miss", {31'd0, lock_lost}, 32'd1);
  endtask

  task automatic t_full();
    do_reset(8'h47, 8'd188, 4'd9, 4'd9);
    for (int p = 0; p < 8; p++) send_pkt(8'h47, 1'b0, 1'b0, "R2 full verify");
    send_pkt(8'h47, 1'b1, 1'b1, "R3 lock on ninth sync");
    for (int p = 0; p < 8; p++) send_pkt(8'h00, 1'b1, 1'b1, "R6 misses below drop");
    send_pkt(8'h00, 1'b0, 1'b0, "R7 drop on ninth miss");
    check(lock_lost, "R8 flag at full drop", {31'd0, lock_lost}, 32'd1);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_lock();
    t_verify_miss();
    t_drop();
    t_gaps();
    t_token();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule